// File: doc/BRIEF.md
# Byte Load/Store Execution Unit

This block executes the data-movement subset of a small 8-bit accumulator processor. It owns seven byte registers (A, B, C, D, E, H, L), a 16-bit stack pointer and a program counter. It fetches opcode and operand bytes over a byte-wide memory port, decodes the load/store opcode group and carries out one instruction at a time. The supported operations are register copies, immediate loads, reads and writes through the BC, DE and HL pointers, absolute-address accesses, accesses to a fixed high I/O page, HL auto-step loads and a store of the stack pointer.

Each instruction is one, two or three bytes long. When an instruction completes, the program counter rests on the first byte after its operands, so that byte is fetched as the next opcode. Any opcode outside the supported group completes as a one-byte instruction and raises an illegal flag. It changes no register and no memory. A single-cycle done pulse marks the end of every instruction.

The memory port issues one read or one write per cycle. Read data is expected on `mem_rdata` in the cycle after the read request.

Top module: `ldst_unit`

## Requirements
- R1: A synchronous active-low reset clears A, B, C, D, E, H and L to 0x00 and loads SP with SP_INIT (default 0xFFFE). In the first cycle after reset the unit requests a read at PC_INIT (default 0x0000), with done and illegal low.
- R2: An opcode 0x40-0x7F whose fields are both register codes copies a register. Bits 5:3 name the destination and bits 2:0 name the source, with B=0, C=1, D=2, E=3, H=4, L=5, A=7. Self-copies leave the value unchanged.
- R3: Field value 6 in the 0x40-0x7F range names the memory byte at address {H,L}. A source of 6 loads that byte into the destination register. A destination of 6 (0x70-0x75, 0x77) writes the source register to that address.
- R4: Opcodes 0x00-0x3F with bits 2:0 = 6 and bits 5:3 naming a register load the following byte into that register (0x06 B, 0x0E C, 0x16 D, 0x1E E, 0x26 H, 0x2E L, 0x3E A).
- R5: 0x0A and 0x1A load A from the byte addressed by {B,C} and {D,E}. 0x02 and 0x12 write A to those addresses.
- R6: 0x36 writes the byte following the opcode to address {H,L}.
- R7: 0xFA loads A from a 16-bit address, and 0xEA writes A to one. In both, the address is carried in the two following bytes, low byte first.
- R8: 0xF2 loads A from 0xFF00+C, and 0xE2 writes A to 0xFF00+C.
- R9: 0xF0 loads A from 0xFF00 plus the following byte, and 0xE0 writes A there.
- R10: 0x2A loads A from {H,L} and then adds one to HL. 0x3A does the same and then subtracts one. Carries and borrows propagate between L and H.
- R11: 0x08 takes a 16-bit address n (low byte first). It writes SP[7:0] to n and SP[15:8] to n+1 in two consecutive cycles.
- R12: Instruction length is 3 bytes for 0xFA, 0xEA and 0x08. It is 2 bytes for the R4 opcodes, 0x36, 0xF0 and 0xE0, and 1 byte otherwise. The fetch that follows a done pulse is at the first byte past the operands.
- R13: 0x76 and every opcode not listed in R2-R11 is illegal. It completes as a one-byte instruction with done and illegal high in the same cycle, and it writes no memory and no register.
- R14: A cycle never holds both a read and a write request. Done is high for exactly one cycle per instruction, in the cycle that requests the next opcode fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Byte address of the current memory request |
| mem_rd | output | 1 | Read request; data expected on mem_rdata one cycle later |
| mem_wr | output | 1 | Write request for mem_wdata at mem_addr |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data returned one cycle after mem_rd |
| instr_done | output | 1 | One-cycle pulse at the end of each instruction |
| instr_illegal | output | 1 | High with instr_done when the instruction was not recognised |

## Verification
The cycle-level properties of the port are checked by assertions on every clock. These are: no read and write in the same cycle, done lasting one cycle and coinciding with a fetch, illegal only with done, the first fetch address after reset, and the consecutive addresses of the two stack-pointer bytes. The data path can only be shown by the bench scenarios, because register contents are visible only through later stores. These scenarios cover each register-copy pair, the decoded pointer and page addresses, the auto-step carry across the L/H boundary, the byte order of absolute addresses, and the length and legality of all 256 opcodes.

// File: rtl/ldst_pkg.sv
// Shared types for the load/store execution unit.
// Assumes the fixed 3-bit register field encoding of the opcode map.
package ldst_pkg;

    // operation class produced by the decoder
    typedef enum logic [2:0] {
        K_ILL, K_MOVE, K_IMM, K_LOAD, K_STORE, K_STIMM, K_STSP
    } kind_e;

    // effective-address source for memory operations
    typedef enum logic [2:0] {
        AM_HL, AM_BC, AM_DE, AM_PGC, AM_PGN, AM_ABS
    } amode_e;

    // pointer adjustment applied after a load
    typedef enum logic [1:0] {
        HS_NONE, HS_INC, HS_DEC
    } hstep_e;

    // register field codes
    localparam logic [2:0] RC_B   = 3'd0;
    localparam logic [2:0] RC_C   = 3'd1;
    localparam logic [2:0] RC_D   = 3'd2;
    localparam logic [2:0] RC_E   = 3'd3;
    localparam logic [2:0] RC_H   = 3'd4;
    localparam logic [2:0] RC_L   = 3'd5;
    localparam logic [2:0] RC_MEM = 3'd6;
    localparam logic [2:0] RC_A   = 3'd7;

    typedef struct packed {
        kind_e      kind;
        amode_e     amode;
        hstep_e     step;
        logic [1:0] nargs;
        logic [2:0] dst;
        logic [2:0] src;
    } dec_t;

endpackage

// File: rtl/ldst_decode.sv
// Opcode decoder for the load/store group.
// Purely combinational; any opcode not in the group decodes as K_ILL.
module ldst_decode
    import ldst_pkg::*;
(
    input  logic [7:0] op,
    output dec_t       dec
);

    // map one opcode byte to its operation class, addressing and fields
    always_comb begin
        dec = '{kind: K_ILL, amode: AM_HL, step: HS_NONE, nargs: 2'd0,
                dst: RC_A, src: RC_A};
        if (op[7:6] == 2'b01) begin
            if (op != 8'h76) begin
                if (op[2:0] == RC_MEM) begin
                    dec.kind = K_LOAD;
                    dec.dst  = op[5:3];
                end else if (op[5:3] == RC_MEM) begin
                    dec.kind = K_STORE;
                    dec.src  = op[2:0];
                end else begin
                    dec.kind = K_MOVE;
                    dec.dst  = op[5:3];
                    dec.src  = op[2:0];
                end
            end
        end else if (op[7:6] == 2'b00 && op[2:0] == 3'd6) begin
            dec.nargs = 2'd1;
            if (op[5:3] == RC_MEM) begin
                dec.kind = K_STIMM;
            end else begin
                dec.kind = K_IMM;
                dec.dst  = op[5:3];
            end
        end else begin
            case (op)
                8'h0A: begin dec.kind = K_LOAD;  dec.amode = AM_BC; end
                8'h1A: begin dec.kind = K_LOAD;  dec.amode = AM_DE; end
                8'h02: begin dec.kind = K_STORE; dec.amode = AM_BC; end
                8'h12: begin dec.kind = K_STORE; dec.amode = AM_DE; end
                8'h2A: begin dec.kind = K_LOAD;  dec.step = HS_INC; end
                8'h3A: begin dec.kind = K_LOAD;  dec.step = HS_DEC; end
                8'h08: begin
                    dec.kind = K_STSP; dec.amode = AM_ABS; dec.nargs = 2'd2;
                end
                8'hFA: begin
                    dec.kind = K_LOAD; dec.amode = AM_ABS; dec.nargs = 2'd2;
                end
                8'hEA: begin
                    dec.kind = K_STORE; dec.amode = AM_ABS; dec.nargs = 2'd2;
                end
                8'hF2: begin dec.kind = K_LOAD;  dec.amode = AM_PGC; end
                8'hE2: begin dec.kind = K_STORE; dec.amode = AM_PGC; end
                8'hF0: begin
                    dec.kind = K_LOAD; dec.amode = AM_PGN; dec.nargs = 2'd1;
                end
                8'hE0: begin
                    dec.kind = K_STORE; dec.amode = AM_PGN; dec.nargs = 2'd1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ldst_regs.sv
// Register file: seven byte registers addressed by field code (code 6 unused,
// reads as zero), one read port, one write port and an HL pair write port.
// Assumes the sequencer never writes H or L through both ports in one cycle;
// if it did, the single-register port would win.
module ldst_regs
    import ldst_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                hl_wr_en,
    input  logic [2*DATA_W-1:0] hl_wr_data,
    input  logic [2:0]          rd_sel,
    output logic [DATA_W-1:0]   rd_data,
    output logic [2*DATA_W-1:0] bc,
    output logic [2*DATA_W-1:0] de,
    output logic [2*DATA_W-1:0] hl
);

    localparam int NREG = 8;

    logic [NREG-1:0][DATA_W-1:0] rfile;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == int'(RC_MEM)) begin : g_hole
            assign rfile[i] = '0;
        end else begin : g_flop
            logic [DATA_W-1:0] q;
            logic              pair_hit;
            logic [DATA_W-1:0] pair_val;

            // pick the HL pair half that belongs to this register, if any
            always_comb begin
                pair_hit = 1'b0;
                pair_val = '0;
                if (i == int'(RC_H)) begin
                    pair_hit = hl_wr_en;
                    pair_val = hl_wr_data[2*DATA_W-1:DATA_W];
                end else if (i == int'(RC_L)) begin
                    pair_hit = hl_wr_en;
                    pair_val = hl_wr_data[DATA_W-1:0];
                end
            end

            // hold the register value, single-register write has priority
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && wr_sel == 3'(i)) begin
                    q <= wr_data;
                end else if (pair_hit) begin
                    q <= pair_val;
                end
            end

            assign rfile[i] = q;
        end
    end

    assign rd_data = rfile[rd_sel];
    assign bc      = {rfile[RC_B], rfile[RC_C]};
    assign de      = {rfile[RC_D], rfile[RC_E]};
    assign hl      = {rfile[RC_H], rfile[RC_L]};

endmodule

// File: rtl/ldst_seq.sv
// Instruction sequencer: fetches opcode and operand bytes, forms effective
// addresses, drives the memory port and the register file write ports, and
// pulses done/illegal one cycle after the final action of each instruction.
// Assumes read data arrives on mem_rdata the cycle after a read request.
module ldst_seq
    import ldst_pkg::*;
#(
    parameter int                    DATA_W  = 8,
    parameter logic [2*DATA_W-1:0]   PC_INIT = '0,
    parameter logic [2*DATA_W-1:0]   SP_INIT = {{(2*DATA_W-1){1'b1}}, 1'b0},
    parameter logic [DATA_W-1:0]     IO_PAGE = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                done,
    output logic                illegal,
    output logic [7:0]          op_byte,
    input  dec_t                dec,
    output logic                rf_we,
    output logic [2:0]          rf_sel,
    output logic [DATA_W-1:0]   rf_wdata,
    output logic                hl_we,
    output logic [2*DATA_W-1:0] hl_wdata,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic [2*DATA_W-1:0] bc,
    input  logic [2*DATA_W-1:0] de,
    input  logic [2*DATA_W-1:0] hl
);

    localparam int ADDR_W = 2 * DATA_W;

    typedef enum logic [2:0] {
        S_FETCH, S_DECODE, S_ARG1, S_ARG2, S_ARG3, S_EXEC, S_LOADW, S_SPHI
    } state_e;

    state_e              state_q, state_d;
    logic [ADDR_W-1:0]   pc_q;
    logic [ADDR_W-1:0]   sp_q;
    logic [7:0]          ir_q;
    logic [DATA_W-1:0]   lo_q, hi_q;
    logic                pc_inc, cap_lo, cap_hi, fin, ill;
    logic                done_q, ill_q;
    logic [ADDR_W-1:0]   ea;

    // the decoder sees the fresh byte while decoding, the held opcode after
    assign op_byte = (state_q == S_DECODE) ? mem_rdata[7:0] : ir_q;

    // effective address for the decoded addressing mode
    always_comb begin
        case (dec.amode)
            AM_BC:   ea = bc;
            AM_DE:   ea = de;
            AM_PGC:  ea = {IO_PAGE, bc[DATA_W-1:0]};
            AM_PGN:  ea = {IO_PAGE, lo_q};
            AM_ABS:  ea = {hi_q, lo_q};
            default: ea = hl;
        endcase
    end

    // next-state and per-cycle control outputs
    always_comb begin
        state_d   = state_q;
        pc_inc    = 1'b0;
        cap_lo    = 1'b0;
        cap_hi    = 1'b0;
        fin       = 1'b0;
        ill       = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = pc_q;
        mem_wdata = rd_data;
        rf_we     = 1'b0;
        rf_sel    = dec.dst;
        rf_wdata  = lo_q;
        hl_we     = 1'b0;
        hl_wdata  = hl;
        case (state_q)
            S_FETCH: begin
                mem_rd  = 1'b1;
                pc_inc  = 1'b1;
                state_d = S_DECODE;
            end
            S_DECODE: begin
                if (dec.kind == K_ILL) begin
                    fin = 1'b1;
                    ill = 1'b1;
                end else if (dec.kind == K_MOVE) begin
                    rf_we    = 1'b1;
                    rf_wdata = rd_data;
                    fin      = 1'b1;
                end else if (dec.nargs != 2'd0) begin
                    state_d = S_ARG1;
                end else begin
                    state_d = S_EXEC;
                end
            end
            S_ARG1: begin
                mem_rd  = 1'b1;
                pc_inc  = 1'b1;
                state_d = S_ARG2;
            end
            S_ARG2: begin
                cap_lo = 1'b1;
                if (dec.nargs == 2'd2) begin
                    mem_rd  = 1'b1;
                    pc_inc  = 1'b1;
                    state_d = S_ARG3;
                end else begin
                    state_d = S_EXEC;
                end
            end
            S_ARG3: begin
                cap_hi  = 1'b1;
                state_d = S_EXEC;
            end
            S_EXEC: begin
                mem_addr = ea;
                case (dec.kind)
                    K_IMM: begin
                        rf_we = 1'b1;
                        fin   = 1'b1;
                    end
                    K_LOAD: begin
                        mem_rd  = 1'b1;
                        state_d = S_LOADW;
                    end
                    K_STORE: begin
                        mem_wr = 1'b1;
                        fin    = 1'b1;
                    end
                    K_STIMM: begin
                        mem_wr    = 1'b1;
                        mem_wdata = lo_q;
                        fin       = 1'b1;
                    end
                    K_STSP: begin
                        mem_wr    = 1'b1;
                        mem_wdata = sp_q[DATA_W-1:0];
                        state_d   = S_SPHI;
                    end
                    default: fin = 1'b1;
                endcase
            end
            S_LOADW: begin
                rf_we    = 1'b1;
                rf_wdata = mem_rdata;
                fin      = 1'b1;
                if (dec.step == HS_INC) begin
                    hl_we    = 1'b1;
                    hl_wdata = hl + ADDR_W'(1);
                end else if (dec.step == HS_DEC) begin
                    hl_we    = 1'b1;
                    hl_wdata = hl - ADDR_W'(1);
                end
            end
            S_SPHI: begin
                mem_addr  = {hi_q, lo_q} + ADDR_W'(1);
                mem_wr    = 1'b1;
                mem_wdata = sp_q[ADDR_W-1:DATA_W];
                fin       = 1'b1;
            end
            default: state_d = S_FETCH;
        endcase
        if (fin) begin
            state_d = S_FETCH;
        end
    end

    // state, program counter, opcode and operand holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_FETCH;
            pc_q    <= PC_INIT;
            sp_q    <= SP_INIT;
            ir_q    <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            done_q  <= 1'b0;
            ill_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= fin;
            ill_q   <= ill;
            if (pc_inc) pc_q <= pc_q + ADDR_W'(1);
            if (state_q == S_DECODE) ir_q <= mem_rdata[7:0];
            if (cap_lo) lo_q <= mem_rdata;
            if (cap_hi) hi_q <= mem_rdata;
        end
    end

    assign done    = done_q;
    assign illegal = ill_q;

endmodule

// File: rtl/ldst_unit.sv
// Top of the load/store execution unit: decoder, register file and
// sequencer joined together. Assumes a byte memory with one-cycle read latency.
module ldst_unit
    import ldst_pkg::*;
#(
    parameter int                    DATA_W  = 8,
    parameter logic [2*DATA_W-1:0]   PC_INIT = '0,
    parameter logic [2*DATA_W-1:0]   SP_INIT = {{(2*DATA_W-1){1'b1}}, 1'b0},
    parameter logic [DATA_W-1:0]     IO_PAGE = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                instr_done,
    output logic                instr_illegal
);

    localparam int ADDR_W = 2 * DATA_W;

    logic [7:0]        op_byte;
    dec_t              dec;
    logic              rf_we, hl_we;
    logic [2:0]        rf_sel;
    logic [DATA_W-1:0] rf_wdata, rd_data;
    logic [ADDR_W-1:0] hl_wdata, bc, de, hl;

    ldst_decode u_dec (
        .op  (op_byte),
        .dec (dec)
    );

    ldst_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (rf_we),
        .wr_sel     (rf_sel),
        .wr_data    (rf_wdata),
        .hl_wr_en   (hl_we),
        .hl_wr_data (hl_wdata),
        .rd_sel     (dec.src),
        .rd_data    (rd_data),
        .bc         (bc),
        .de         (de),
        .hl         (hl)
    );

    ldst_seq #(
        .DATA_W  (DATA_W),
        .PC_INIT (PC_INIT),
        .SP_INIT (SP_INIT),
        .IO_PAGE (IO_PAGE)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .done      (instr_done),
        .illegal   (instr_illegal),
        .op_byte   (op_byte),
        .dec       (dec),
        .rf_we     (rf_we),
        .rf_sel    (rf_sel),
        .rf_wdata  (rf_wdata),
        .hl_we     (hl_we),
        .hl_wdata  (hl_wdata),
        .rd_data   (rd_data),
        .bc        (bc),
        .de        (de),
        .hl        (hl)
    );

endmodule

// File: rtl/ldst_unit_chk.sv
// Port-level protocol checker for ldst_unit, attached by bind below.
// Assumes the synchronous active-low reset of the unit.
module ldst_unit_chk #(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] PC_INIT = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              instr_done,
    input logic              instr_illegal
);

    // R14: one memory access per cycle
    a_r14_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R14: done lasts exactly one cycle
    a_r14_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> !instr_done);

    // R12: done coincides with the fetch of the next opcode
    a_r12_done_at_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> mem_rd);

    // R13: illegal is only reported together with done
    a_r13_illegal_done: assert property (@(posedge clk) disable iff (!rst_n)
        instr_illegal |-> instr_done);

    // R11: back-to-back writes only for the stack pointer pair, at n then n+1
    a_r11_sp_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R1: first cycle after reset fetches at the reset address
    a_r1_first_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mem_rd && mem_addr == PC_INIT && !instr_done));

endmodule

bind ldst_unit ldst_unit_chk #(.ADDR_W(2*DATA_W), .PC_INIT(PC_INIT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_addr      (mem_addr),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .instr_done    (instr_done),
    .instr_illegal (instr_illegal)
);

// File: tb/ldst_unit_bench.sv
`timescale 1ns/1ps
module ldst_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        instr_done, instr_illegal;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ldst_unit u_ldst_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .mem_addr      (mem_addr),
        .mem_rd        (mem_rd),
        .mem_wr        (mem_wr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .instr_done    (instr_done),
        .instr_illegal (instr_illegal)
    );

    // sparse byte memory with one-cycle read latency, plus write/done logs
    logic [7:0]  mem [logic [15:0]];
    logic [15:0] wlog_a [16];
    logic [7:0]  wlog_d [16];
    logic [15:0] dlog_pc [16];
    logic        dlog_ill [16];
    int          wcount = 0;
    int          dcount = 0;
    logic        both_seen = 1'b0;

    function automatic logic [7:0] rd8(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= rd8(mem_addr);
        if (!rst_n) begin
            wcount <= 0;
            dcount <= 0;
        end else begin
            if (mem_rd && mem_wr) both_seen <= 1'b1;
            if (mem_wr) begin
                mem[mem_addr] = mem_wdata;
                if (wcount < 16) begin
                    wlog_a[wcount] <= mem_addr;
                    wlog_d[wcount] <= mem_wdata;
                end
                wcount <= wcount + 1;
            end
            if (instr_done) begin
                if (dcount < 16) begin
                    dlog_pc[dcount]  <= mem_addr;
                    dlog_ill[dcount] <= instr_illegal;
                end
                dcount <= dcount + 1;
            end
        end
    end

    logic [7:0] prog [64];
    int         plen = 0;
    bit         first_run = 1'b1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        prog[plen] = b;
        plen++;
    endtask

    task automatic begin_test();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        mem.delete();
        plen = 0;
    endtask

    task automatic go(input int n);
        int guard = 0;
        for (int i = 0; i < plen; i++) mem[16'(i)] = prog[i];
        @(negedge clk);
        rst_n = 1'b1;
        if (first_run) begin
            first_run = 1'b0;
            chk("R1 first read request", 32'(mem_rd), 32'd1);
            chk("R1 first fetch address", 32'(mem_addr), 32'h0000);
            chk("R1 done low after reset", 32'(instr_done), 32'd0);
            chk("R1 illegal low after reset", 32'(instr_illegal), 32'd0);
        end
        while (dcount < n && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        chk("R14 instruction completion count", 32'(dcount >= n), 32'd1);
    endtask

    function automatic bit is_legal(input logic [7:0] op);
        if (op[7:6] == 2'b01) return op != 8'h76;
        if (op[7:6] == 2'b00 && op[2:0] == 3'd6) return 1'b1;
        case (op)
            8'h0A, 8'h1A, 8'h02, 8'h12, 8'h2A, 8'h3A, 8'h08,
            8'hFA, 8'hEA, 8'hF2, 8'hE2, 8'hF0, 8'hE0: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int op_len(input logic [7:0] op);
        if (!is_legal(op)) return 1;
        if (op == 8'hFA || op == 8'hEA || op == 8'h08) return 3;
        if (op == 8'hF0 || op == 8'hE0) return 2;
        if (op[7:6] == 2'b00 && op[2:0] == 3'd6) return 2;
        return 1;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R14 watchdog expired actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] init_v [8];
        logic [7:0] v [8];
        init_v[0] = 8'h31; init_v[1] = 8'h42; init_v[2] = 8'h53; init_v[3] = 8'h64;
        init_v[4] = 8'h75; init_v[5] = 8'h86; init_v[6] = 8'h00; init_v[7] = 8'h97;

        // R1 reset values and R11 stack pointer store across a page carry
        begin_test();
        put(8'h77);
        put(8'h08); put(8'hFF); put(8'h02);
        go(2);
        chk("R1 A cleared (store addr)", 32'(wlog_a[0]), 32'h0000);
        chk("R1 A cleared (store data)", 32'(wlog_d[0]), 32'h00);
        chk("R11 SP low address", 32'(wlog_a[1]), 32'h02FF);
        chk("R11 SP low byte", 32'(wlog_d[1]), 32'hFE);
        chk("R11 SP high address", 32'(wlog_a[2]), 32'h0300);
        chk("R11 SP high byte", 32'(wlog_d[2]), 32'hFF);
        chk("R12 pc after 3-byte SP store", 32'(dlog_pc[1]), 32'd4);

        // R2/R4 register copy sweep; observed via store through {H,L}
        for (int d = 0; d < 8; d++) begin
            for (int s = 0; s < 8; s++) begin
                if (d != 6 && s != 6) begin
                    begin_test();
                    for (int r = 0; r < 8; r++) begin
                        if (r != 6) begin
                            put(8'((r << 3) | 6));
                            put(init_v[r]);
                        end
                        v[r] = init_v[r];
                    end
                    put(8'(8'h40 | (d << 3) | s));
                    put(8'(8'h70 | d));
                    go(9);
                    v[d] = v[s];
                    if (d == s)
                        chk($sformatf("R4 immediate load reg %0d", d), 32'(wlog_d[0]), 32'(init_v[d]));
                    else
                        chk($sformatf("R2 copy %0d<-%0d", d, s), 32'(wlog_d[0]), 32'(v[d]));
                    chk($sformatf("R3 store address after copy %0d<-%0d", d, s),
                        32'(wlog_a[0]), 32'({v[4], v[5]}));
                    chk("R12 pc after 1-byte copy", 32'(dlog_pc[7]), 32'd15);
                end
            end
        end

        // R3 load from {H,L} into each register, then store it back
        for (int d = 0; d < 8; d++) begin
            if (d != 6) begin
                begin_test();
                put(8'h26); put(8'h40); put(8'h2E); put(8'h10);
                put(8'(8'h46 | (d << 3)));
                put(8'(8'h70 | d));
                mem[16'h4010] = 8'h5A;
                go(4);
                for (int r = 0; r < 8; r++) v[r] = 8'h00;
                v[4] = 8'h40; v[5] = 8'h10; v[d] = 8'h5A;
                chk($sformatf("R3 load via HL into %0d", d), 32'(wlog_d[0]), 32'h5A);
                chk($sformatf("R3 store address for %0d", d), 32'(wlog_a[0]), 32'({v[4], v[5]}));
            end
        end

        // R5 pointer pairs BC and DE
        begin_test();
        put(8'h06); put(8'h12); put(8'h0E); put(8'h34);
        put(8'h16); put(8'h23); put(8'h1E); put(8'h45);
        put(8'h0A); put(8'h12);
        put(8'h3E); put(8'h00);
        put(8'h1A); put(8'h02);
        mem[16'h1234] = 8'hA1;
        go(10);
        chk("R5 store A via DE address", 32'(wlog_a[0]), 32'h2345);
        chk("R5 load A via BC data", 32'(wlog_d[0]), 32'hA1);
        chk("R5 store A via BC address", 32'(wlog_a[1]), 32'h1234);
        chk("R5 load A via DE data", 32'(wlog_d[1]), 32'hA1);

        // R6 immediate byte stored through HL
        begin_test();
        put(8'h26); put(8'h30); put(8'h2E); put(8'h01);
        put(8'h36); put(8'hE7);
        go(3);
        chk("R6 store address", 32'(wlog_a[0]), 32'h3001);
        chk("R6 store data", 32'(wlog_d[0]), 32'hE7);
        chk("R12 pc after 2-byte store", 32'(dlog_pc[2]), 32'd6);

        // R7 absolute addresses, low byte first
        begin_test();
        put(8'hFA); put(8'h56); put(8'h34);
        put(8'hEA); put(8'h78); put(8'h56);
        mem[16'h3456] = 8'h6D;
        go(2);
        chk("R12 pc after 3-byte load", 32'(dlog_pc[0]), 32'd3);
        chk("R7 absolute store address", 32'(wlog_a[0]), 32'h5678);
        chk("R7 absolute load data", 32'(wlog_d[0]), 32'h6D);

        // R8 high page indexed by C
        begin_test();
        put(8'h0E); put(8'h64); put(8'hF2);
        put(8'h0E); put(8'h80); put(8'hE2);
        mem[16'hFF64] = 8'h9C;
        go(4);
        chk("R8 page-C store address", 32'(wlog_a[0]), 32'hFF80);
        chk("R8 page-C load data", 32'(wlog_d[0]), 32'h9C);

        // R9 high page indexed by immediate
        begin_test();
        put(8'hF0); put(8'h05); put(8'hE0); put(8'h21);
        mem[16'hFF05] = 8'hAF;
        go(2);
        chk("R9 page-imm store address", 32'(wlog_a[0]), 32'hFF21);
        chk("R9 page-imm load data", 32'(wlog_d[0]), 32'hAF);
        chk("R12 pc after 2-byte page load", 32'(dlog_pc[0]), 32'd2);

        // R10 post-increment with carry from L into H
        begin_test();
        put(8'h26); put(8'h40); put(8'h2E); put(8'hFF);
        put(8'h2A); put(8'h2A); put(8'h77);
        mem[16'h40FF] = 8'h11; mem[16'h4100] = 8'h22;
        go(5);
        chk("R10 increment store address", 32'(wlog_a[0]), 32'h4101);
        chk("R10 increment second load", 32'(wlog_d[0]), 32'h22);

        // R10 post-decrement with borrow from H
        begin_test();
        put(8'h26); put(8'h40); put(8'h2E); put(8'h00);
        put(8'h3A); put(8'h3A); put(8'h77);
        mem[16'h4000] = 8'h33; mem[16'h3FFF] = 8'h44;
        go(5);
        chk("R10 decrement store address", 32'(wlog_a[0]), 32'h3FFE);
        chk("R10 decrement second load", 32'(wlog_d[0]), 32'h44);

        // R13 illegal opcodes leave A intact and take one byte
        begin_test();
        put(8'h3E); put(8'h5E); put(8'h76); put(8'hD3); put(8'h77);
        go(4);
        chk("R13 0x76 flagged", 32'(dlog_ill[1]), 32'd1);
        chk("R13 0x76 length", 32'(dlog_pc[1]), 32'd3);
        chk("R13 0xD3 length", 32'(dlog_pc[2]), 32'd4);
        chk("R13 A unchanged by illegal", 32'(wlog_d[0]), 32'h5E);
        chk("R13 single write only", 32'(wcount), 32'd1);

        // R12/R13 legality and length sweep over all opcodes
        for (int op = 0; op < 256; op++) begin
            begin_test();
            put(8'(op)); put(8'h00); put(8'h00);
            go(1);
            chk($sformatf("R13 legality of %02h", op), 32'(dlog_ill[0]), 32'(!is_legal(8'(op))));
            chk($sformatf("R12 length of %02h", op), 32'(dlog_pc[0]), 32'(op_len(8'(op))));
            if (!is_legal(8'(op)))
                chk($sformatf("R13 no write for %02h", op), 32'(wcount), 32'd0);
        end

        chk("R14 never read and write together", 32'(both_seen), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule